// File: doc/BRIEF.md
# Script Memory-Move Copy Engine

This block carries out a single memory-to-memory copy on behalf of a small script processor. The processor hands it a 32-bit command word together with a source address and a destination address, and pulses `start`. The engine checks the command and may issue a one-cycle flush of the instruction prefetch buffer. It then copies the requested bytes one per beat over a byte-wide read request/response port and a byte-wide write port. On completion it raises `done`, or raises `illegal_irq` when the command is malformed.

Each address is classified on its own as it is generated. If its upper bits equal the register-window base input, it falls inside a 128-byte local register file, and the low seven address bits pick the register. A window address never reaches the bus. Because either side of the copy may land in the window, one command can save registers out to memory, restore them from memory, or copy between registers.

Top module: `mmove_engine`

## Requirements
- R1: The command type field, bits [31:29], must equal 3'b110. Any other value raises `illegal_irq`, and no flush, bus access or `done` follows.
- R2: When any of the reserved bits [28:25] is set, `illegal_irq` is raised, and no flush, bus access, register write or `done` follows.
- R3: `illegal_irq` is a single-cycle pulse. It appears in the cycle after the rejected `start` is sampled, and the engine stays idle.
- R4: When `prefetch_en` is 1 and the no-flush bit 24 is 0, `flush_pulse` is high for exactly one cycle. That cycle is the one after `start`, and it comes before any read request of the copy.
- R5: When bit 24 is 1, or `prefetch_en` is 0 at `start`, no flush pulse is produced.
- R6: Bits [23:0] give an unsigned byte count N. Byte i is read from source+i and written to destination+i, for i from 0 up to N-1, in ascending order. A write held by `wr_ready` low keeps its address and data.
- R7: An address whose bits [31:7] equal `reg_base_hi` selects internal register address[6:0] and causes no bus request. The decision is made per byte, so a copy may cross the window edge.
- R8: Registers written by a memory-to-window copy return the same bytes when later copied from the window back to memory.
- R9: A count of zero makes no memory or register access. `done` follows in the next cycle, or in the cycle after the flush pulse when a flush applies.
- R10: `done` is a single-cycle pulse, asserted in the cycle after the final byte is written.
- R11: `start` is ignored while `busy` is high.
- R12: After reset, all outputs are low and every internal register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing the presented command |
| cmd_word | input | 32 | Type, reserved, no-flush and byte-count fields |
| src_addr | input | 32 | First source byte address |
| dst_addr | input | 32 | First destination byte address |
| prefetch_en | input | 1 | Prefetch is enabled, so the no-flush bit is honoured |
| reg_base_hi | input | 25 | Upper address bits that identify the register window |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 8 | Write data byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Copy completed (one-cycle pulse) |
| illegal_irq | output | 1 | Command rejected (one-cycle pulse) |
| flush_pulse | output | 1 | Flush the prefetch buffer (one-cycle pulse) |

## Verification
A wrong address counter or byte count shows up at the next write handshake as a wrong `wr_addr` or `wr_data`, or as a write nobody expected. Missing writes show up when `done` is not seen in the cycle after the last one. A bad window decision shows up at once as a bus request inside the window, or later as a register save that returns the wrong bytes. A state machine that mis-sequences after decode shows up in the first cycle after `start`, through the presence or absence of the flush, interrupt or zero-count done.

// File: rtl/mmove_pkg.sv
// Shared definitions for the memory-move copy engine.
// Assumes byte-addressed memory and one byte moved per beat.
package mmove_pkg;

    localparam logic [2:0] MM_TYPE_CODE = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_READ,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } mm_state_t;

endpackage

// File: rtl/mmove_decode.sv
// Splits the command word into its fields and judges its legality.
// Assumes the layout: type [31:29], reserved [28:25], no-flush [24], count [23:0].
module mmove_decode
    import mmove_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [31:0]      cmd_word,
    input  logic             prefetch_en,
    output logic             legal,
    output logic             need_flush,
    output logic [CNT_W-1:0] count
);
    localparam int TYPE_LSB = 29;
    localparam int RSVD_LSB = 25;
    localparam int NF_BIT   = 24;

    logic type_ok;
    logic rsvd_ok;
    logic no_flush;

    // Field extraction and legality checks.
    always_comb begin
        type_ok    = (cmd_word[31:TYPE_LSB] == MM_TYPE_CODE);
        rsvd_ok    = (cmd_word[TYPE_LSB-1:RSVD_LSB] == '0);
        no_flush   = cmd_word[NF_BIT];
        legal      = type_ok && rsvd_ok;
        need_flush = prefetch_en && !no_flush;
        count      = cmd_word[CNT_W-1:0];
    end

endmodule

// File: rtl/mmove_window.sv
// Compares the upper bits of an address with the register-window base.
// Assumes the window is a naturally aligned power-of-two block.
module mmove_window #(
    parameter int HI_W = 25
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] base_hi,
    output logic            hit
);
    // Equality of the upper address bits.
    always_comb hit = (addr_hi == base_hi);

endmodule

// File: rtl/mmove_regfile.sv
// Byte-wide local register file behind the address window.
// Assumes one combinational read port and one synchronous write port.
module mmove_regfile #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] regs [DEPTH];

    // Clear on reset and take one byte write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // Asynchronous read of the selected register.
    always_comb rdata = regs[ridx];

endmodule

// File: rtl/mmove_ctrl.sv
// Sequencer for one copy: idle, optional flush, then read/write per byte, then done.
// Assumes a single outstanding read and the window hit flags for the current addresses.
module mmove_ctrl
    import mmove_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic              need_flush,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic              src_int,
    input  logic              dst_int,
    input  logic [7:0]        rf_rdata,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [7:0]        rd_rsp_data,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              rd_req_valid,
    output logic              wr_valid,
    output logic [7:0]        byte_q,
    output logic              rf_we,
    output logic              busy,
    output logic              done,
    output logic              illegal_irq,
    output logic              flush_pulse
);
    mm_state_t         state;
    logic [CNT_W-1:0]  remain_q;
    logic              irq_q;
    logic              write_fire;

    // A byte leaves the engine either into the register file or over the bus.
    always_comb write_fire = (state == ST_WRITE) && (dst_int || wr_ready);

    // State, address, count and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_src  <= '0;
            cur_dst  <= '0;
            remain_q <= '0;
            byte_q   <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!legal) begin
                            irq_q <= 1'b1;
                        end else begin
                            cur_src  <= src_in;
                            cur_dst  <= dst_in;
                            remain_q <= count_in;
                            if (need_flush)          state <= ST_FLUSH;
                            else if (count_in == '0) state <= ST_DONE;
                            else                     state <= ST_READ;
                        end
                    end
                end
                ST_FLUSH: begin
                    state <= (remain_q == '0) ? ST_DONE : ST_READ;
                end
                ST_READ: begin
                    if (src_int) begin
                        byte_q <= rf_rdata;
                        state  <= ST_WRITE;
                    end else if (rd_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        byte_q <= rd_rsp_data;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (write_fire) begin
                        cur_src  <= cur_src + ADDR_W'(1);
                        cur_dst  <= cur_dst + ADDR_W'(1);
                        remain_q <= remain_q - CNT_W'(1);
                        state    <= (remain_q == CNT_W'(1)) ? ST_DONE : ST_READ;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Port-level strobes derived from the current state.
    always_comb begin
        rd_req_valid = (state == ST_READ) && !src_int;
        wr_valid     = (state == ST_WRITE) && !dst_int;
        rf_we        = (state == ST_WRITE) && dst_int;
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
        flush_pulse  = (state == ST_FLUSH);
        illegal_irq  = irq_q;
    end

endmodule

// File: rtl/mmove_engine.sv
// Top of the memory-move copy engine: decode, two window comparators,
// the sequencer and the local register file.
// Assumes reg_base_hi and the addresses stay stable while a copy runs.
module mmove_engine #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 24,
    parameter int WIN_BITS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [31:0]                cmd_word,
    input  logic [ADDR_W-1:0]          src_addr,
    input  logic [ADDR_W-1:0]          dst_addr,
    input  logic                       prefetch_en,
    input  logic [ADDR_W-WIN_BITS-1:0] reg_base_hi,
    output logic                       rd_req_valid,
    input  logic                       rd_req_ready,
    output logic [ADDR_W-1:0]          rd_req_addr,
    input  logic                       rd_rsp_valid,
    input  logic [7:0]                 rd_rsp_data,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [7:0]                 wr_data,
    output logic                       busy,
    output logic                       done,
    output logic                       illegal_irq,
    output logic                       flush_pulse
);
    localparam int HI_W  = ADDR_W - WIN_BITS;
    localparam int SIDES = 2;

    logic             legal;
    logic             need_flush;
    logic [CNT_W-1:0] count;
    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_dst;
    logic [ADDR_W-1:0] side_addr [SIDES];
    logic [SIDES-1:0]  side_hit;
    logic              rf_we;
    logic [7:0]        rf_rdata;
    logic [7:0]        byte_q;

    mmove_decode #(.CNT_W(CNT_W)) u_decode (
        .cmd_word    (cmd_word),
        .prefetch_en (prefetch_en),
        .legal       (legal),
        .need_flush  (need_flush),
        .count       (count)
    );

    // Source is side 0, destination is side 1.
    always_comb begin
        side_addr[0] = cur_src;
        side_addr[1] = cur_dst;
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_win
        mmove_window #(.HI_W(HI_W)) u_win (
            .addr_hi (side_addr[g][ADDR_W-1:WIN_BITS]),
            .base_hi (reg_base_hi),
            .hit     (side_hit[g])
        );
    end

    mmove_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .legal        (legal),
        .need_flush   (need_flush),
        .count_in     (count),
        .src_in       (src_addr),
        .dst_in       (dst_addr),
        .src_int      (side_hit[0]),
        .dst_int      (side_hit[1]),
        .rf_rdata     (rf_rdata),
        .rd_req_ready (rd_req_ready),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .wr_ready     (wr_ready),
        .cur_src      (cur_src),
        .cur_dst      (cur_dst),
        .rd_req_valid (rd_req_valid),
        .wr_valid     (wr_valid),
        .byte_q       (byte_q),
        .rf_we        (rf_we),
        .busy         (busy),
        .done         (done),
        .illegal_irq  (illegal_irq),
        .flush_pulse  (flush_pulse)
    );

    mmove_regfile #(.IDX_W(WIN_BITS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .widx  (cur_dst[WIN_BITS-1:0]),
        .wdata (byte_q),
        .ridx  (cur_src[WIN_BITS-1:0]),
        .rdata (rf_rdata)
    );

    // Bus-side address and data come straight from the sequencer registers.
    always_comb begin
        rd_req_addr = cur_src;
        wr_addr     = cur_dst;
        wr_data     = byte_q;
    end

endmodule

// File: rtl/mmove_engine_chk.sv
// Protocol checker for mmove_engine, attached by bind below.
// Assumes only the top-level ports of the engine.
module mmove_engine_chk #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic [31:0]                cmd_word,
    input logic                       prefetch_en,
    input logic [ADDR_W-WIN_BITS-1:0] reg_base_hi,
    input logic                       rd_req_valid,
    input logic [ADDR_W-1:0]          rd_req_addr,
    input logic                       wr_valid,
    input logic                       wr_ready,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [7:0]                 wr_data,
    input logic                       busy,
    input logic                       done,
    input logic                       illegal_irq,
    input logic                       flush_pulse
);
    // R1: wrong type code on an accepted start is rejected.
    p_bad_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_word[31:29] != 3'b110) |=> (illegal_irq && !busy));

    // R2: reserved bits set on an accepted start are rejected.
    p_rsvd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_word[28:25] != 4'b0) |=> (illegal_irq && !busy && !flush_pulse));

    // R3: the interrupt lasts one cycle.
    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_irq |=> !illegal_irq);

    // R4: the flush lasts one cycle and never overlaps a read request.
    p_flush_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> !flush_pulse);
    p_flush_noread_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> !rd_req_valid);

    // R5: a flush only follows a start with prefetch on and no-flush clear.
    p_flush_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(start && !busy && prefetch_en && !cmd_word[24]));

    // R6: a stalled write holds address and data.
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R7: no bus access inside the register window.
    p_rd_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[ADDR_W-1:WIN_BITS] != reg_base_hi));
    p_wr_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[ADDR_W-1:WIN_BITS] != reg_base_hi));

    // R9: a legal zero-count command without flush finishes next cycle.
    p_zero_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_word[31:25] == 7'b1100000 && cmd_word[23:0] == 24'd0
         && !(prefetch_en && !cmd_word[24])) |=> done);

    // R10: done lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a start while busy raises nothing.
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !illegal_irq);

endmodule

bind mmove_engine mmove_engine_chk #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cmd_word     (cmd_word),
    .prefetch_en  (prefetch_en),
    .reg_base_hi  (reg_base_hi),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .busy         (busy),
    .done         (done),
    .illegal_irq  (illegal_irq),
    .flush_pulse  (flush_pulse)
);

// File: tb/mmove_engine_bench.sv
// Self-checking bench: a behavioural model (byte map, register array, write queue)
// predicts each move, and a negedge monitor compares the ports every clock.
module mmove_engine_bench;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic        prefetch_en = 1'b0;
    logic [24:0] reg_base_hi;
    logic        rd_req_valid;
    logic        rd_req_ready;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid;
    logic [7:0]  rd_rsp_data;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        busy;
    logic        done;
    logic        illegal_irq;
    logic        flush_pulse;

    always #5 clk = ~clk;
    assign reg_base_hi = BASE[31:7];

    mmove_engine u_mmove_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .src_addr(src_addr), .dst_addr(dst_addr), .prefetch_en(prefetch_en),
        .reg_base_hi(reg_base_hi), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .illegal_irq(illegal_irq), .flush_pulse(flush_pulse)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Reference state.
    logic [7:0]  mem [logic [31:0]];
    logic [7:0]  mregs [128];
    logic [31:0] exp_wa [$];
    logic [7:0]  exp_wd [$];
    bit          final_ext = 0;
    bit          done_due = 0;
    bit          stall = 0;
    bit          pend = 0;
    logic [31:0] pend_a = '0;
    logic [15:0] lfsr = 16'hACE1;
    int          obs_reads = 0;
    int          obs_flush = 0;
    int          obs_irq = 0;
    int          obs_done = 0;

    function automatic logic [7:0] memget(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic bit is_int(input logic [31:0] a);
        return a[31:7] == BASE[31:7];
    endfunction

    // Per-clock monitor and bus responder.
    initial begin
        rd_req_ready = 1'b0;
        wr_ready     = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rst_n) begin
                if (done_due) begin
                    chk(done === 1'b1, "R10 done in cycle after final write", 32'(done), 1);
                    done_due = 0;
                end
                chk(!(done && illegal_irq), "R3 irq and done exclusive", 32'(illegal_irq), 0);
                if (done) obs_done++;
                if (illegal_irq) obs_irq++;
                if (flush_pulse) begin
                    obs_flush++;
                    chk(obs_reads == 0, "R4 flush before first read", obs_reads, 0);
                end
            end
            rd_rsp_valid = 1'b0;
            if (pend) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = memget(pend_a);
                pend = 0;
            end
            rd_req_ready = stall ? lfsr[0] : 1'b1;
            wr_ready     = stall ? lfsr[3] : 1'b1;
            if (rst_n && rd_req_valid && rd_req_ready) begin
                pend = 1;
                pend_a = rd_req_addr;
                obs_reads++;
                chk(!is_int(rd_req_addr), "R7 bus read outside window", rd_req_addr, 0);
            end
            if (rst_n && wr_valid && wr_ready) begin
                if (exp_wa.size() == 0) begin
                    chk(0, "R6 unexpected write", wr_addr, 0);
                end else begin
                    logic [31:0] ea;
                    logic [7:0]  ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    chk(wr_addr == ea, "R6 write address", wr_addr, ea);
                    chk(wr_data == ed, "R6 write data", 32'(wr_data), 32'(ed));
                    if (exp_wa.size() == 0 && final_ext) done_due = 1;
                end
                mem[wr_addr] = wr_data;
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic run_move(input logic [31:0] cmd, input logic [31:0] src,
                            input logic [31:0] dst, input bit pf, input bit inject);
        int  n;
        bit  legal;
        bit  exp_flush;
        int  exp_reads;
        int  guard;
        n         = int'(cmd[23:0]);
        legal     = (cmd[31:29] == 3'b110) && (cmd[28:25] == 4'b0);
        exp_flush = legal && pf && !cmd[24];
        exp_reads = 0;
        final_ext = 0;
        if (legal) begin
            for (int i = 0; i < n; i++) begin
                logic [31:0] s;
                logic [31:0] d;
                logic [7:0]  b;
                s = src + 32'(i);
                d = dst + 32'(i);
                if (is_int(s)) b = mregs[s[6:0]];
                else begin
                    b = memget(s);
                    exp_reads++;
                end
                if (is_int(d)) mregs[d[6:0]] = b;
                else begin
                    exp_wa.push_back(d);
                    exp_wd.push_back(b);
                end
                if (i == n - 1) final_ext = !is_int(d);
            end
        end
        obs_reads = 0; obs_flush = 0; obs_irq = 0; obs_done = 0;
        cyc();
        start = 1'b1; cmd_word = cmd; src_addr = src; dst_addr = dst; prefetch_en = pf;
        cyc();
        start = 1'b0;
        if (!legal) begin
            chk(illegal_irq == 1'b1, "R3 irq in cycle after start", 32'(illegal_irq), 1);
            chk(busy == 1'b0, "R1 rejected command leaves engine idle", 32'(busy), 0);
            repeat (4) cyc();
        end else begin
            if (exp_flush)
                chk(flush_pulse == 1'b1, "R4 flush in cycle after start", 32'(flush_pulse), 1);
            else
                chk(flush_pulse == 1'b0, "R5 no flush", 32'(flush_pulse), 0);
            if (n == 0 && !exp_flush)
                chk(done == 1'b1, "R9 zero count done next cycle", 32'(done), 1);
            guard = 0;
            while (!done && guard < 4000) begin
                if (inject && guard == 3) begin
                    start = 1'b1;
                    cmd_word = 32'h0000_0003;
                end else begin
                    start = 1'b0;
                end
                cyc();
                guard++;
            end
            start = 1'b0;
            if (n == 0 && exp_flush)
                chk(guard == 1, "R9 zero count done after flush", guard, 1);
            chk(done == 1'b1, "R10 done reached", 32'(done), 1);
            cyc();
            cyc();
        end
        chk(obs_done == (legal ? 1 : 0), "R10 one done per legal command", obs_done, legal ? 1 : 0);
        chk(obs_irq == (legal ? 0 : 1), "R2 irq count", obs_irq, legal ? 0 : 1);
        chk(obs_flush == (exp_flush ? 1 : 0), "R5 flush count", obs_flush, exp_flush ? 1 : 0);
        chk(obs_reads == exp_reads, "R7 bus read count", obs_reads, exp_reads);
        chk(exp_wa.size() == 0, "R6 all writes issued", exp_wa.size(), 0);
        if (inject) chk(obs_irq == 0, "R11 start ignored while busy", obs_irq, 0);
        exp_wa.delete();
        exp_wd.delete();
    endtask

    // Watchdog.
    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mregs[i] = '0;
        repeat (3) cyc();
        chk({busy, done, illegal_irq, flush_pulse, rd_req_valid, wr_valid} == 6'b0,
            "R12 outputs low in reset",
            32'({busy, done, illegal_irq, flush_pulse, rd_req_valid, wr_valid}), 0);
        rst_n = 1'b1;
        cyc();
        // R12: registers read back as zero after reset.
        run_move(32'hC100_0008, BASE + 32'h20, 32'h0000_1000, 1'b0, 1'b0);
        // R6 / R4: plain copy with flush, no stalls.
        run_move(32'hC000_0005, 32'h0000_0100, 32'h0000_2000, 1'b1, 1'b0);
        stall = 1;
        // R5: no-flush bit set, prefetch on.
        run_move(32'hC100_0006, 32'h0000_0300, 32'h0000_2100, 1'b1, 1'b0);
        // R5: prefetch off, no-flush clear.
        run_move(32'hC000_0007, 32'h0000_0400, 32'h0000_2200, 1'b0, 1'b0);
        // R8: restore from memory into registers, then save them back.
        for (int i = 0; i < 16; i++) mem[32'h0000_0500 + 32'(i)] = 8'(8'hC3 + 8'(i * 11));
        run_move(32'hC000_0010, 32'h0000_0500, BASE + 32'h10, 1'b0, 1'b0);
        run_move(32'hC100_0010, BASE + 32'h10, 32'h0000_2300, 1'b1, 1'b0);
        // R7: register-to-register copy, then save.
        run_move(32'hC000_0004, BASE + 32'h12, BASE + 32'h40, 1'b1, 1'b0);
        run_move(32'hC100_0004, BASE + 32'h40, 32'h0000_2400, 1'b0, 1'b0);
        // R7: destination straddles the window top edge.
        run_move(32'hC100_0008, 32'h0000_0600, BASE + 32'h7C, 1'b1, 1'b0);
        run_move(32'hC100_0004, BASE + 32'h7C, 32'h0000_2500, 1'b1, 1'b0);
        // R2: reserved bit set.
        run_move(32'hD000_0004, 32'h0000_0700, 32'h0000_2600, 1'b1, 1'b0);
        // R1: wrong type code.
        run_move(32'h2000_0004, 32'h0000_0700, 32'h0000_2600, 1'b1, 1'b0);
        // R9: zero count, with and without flush.
        run_move(32'hC000_0000, 32'h0000_0700, 32'h0000_2600, 1'b1, 1'b0);
        run_move(32'hC100_0000, 32'h0000_0700, 32'h0000_2600, 1'b1, 1'b0);
        run_move(32'hC000_0000, 32'h0000_0700, 32'h0000_2600, 1'b0, 1'b0);
        // R11: start pulsed while busy.
        run_move(32'hC000_000A, 32'h0000_0800, 32'h0000_2700, 1'b0, 1'b1);
        // R6: longer copy under stalls.
        run_move(32'hC100_0028, 32'h0000_0900, 32'h0000_3000, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule